// File: doc/BRIEF.md
# Byte-Lane Static Memory with Dual Chip Select

This block is a synthesizable word memory that keeps the control behaviour of an asynchronous static RAM and runs on a system clock. Each word holds two byte lanes. The memory is selected only when two enables of opposite polarity agree. One select per lane chooses which bytes take part in an access. A write-enable pin and an output-enable pin together decide whether the access reads, writes or does neither.

A tri-state data pin is replaced by a write-data bus, a read-data bus and a two-bit valid vector, with one valid bit per lane. On every rising clock edge the block samples the control pins and decodes them into one of six modes. A write is committed at that edge. A read fetches the addressed word into an output register, so its data and valid flags appear one cycle after the sampling edge. A registered 3-bit mode code reports what the block decoded in that cycle. The storage array has no reset and is written so that block RAM can be inferred.

Top module: `byte_lane_sram`

## Requirements
- R1: While `rst` is high and in the cycle after it, `mode` is 0 (deselect), `dout_vld` is 0 and `dout` is 0. The address width is `$clog2(DEPTH)`.
- R2: If `sel_lo_n` is 1 or `sel_hi` is 0 at a sampling edge, `mode` is 0 and `dout_vld` is 0 one cycle later, and no lane of the memory is written.
- R3: If both lane selects are 1 (bit 0 is the lower byte, bit 1 the upper byte) while the block is selected, it behaves as deselected: `mode` is 0, no lane is valid and nothing is written.
- R4: A write takes place when the block is selected, `wr_n` is 0 and at least one lane select is 0. Only lanes whose select is 0 take their byte from `din`. `mode` is 3 for the lower lane alone, 4 for the upper lane alone and 5 for both lanes.
- R5: In the cycle after any edge at which `wr_n` is 0, `dout_vld` is 0 whatever `oe_n` is.
- R6: A read takes place when the block is selected, `wr_n` is 1 and `oe_n` is 0. One cycle later `mode` is 2, and only lanes whose select was 0 are valid and carry the stored bytes of the addressed word.
- R7: If the block is selected, at least one lane select is 0, and both `wr_n` and `oe_n` are 1, then `mode` is 1 (output disable) and no lane is valid.
- R8: Each byte of `dout` whose valid bit is 0 is driven as zero.
- R9: A write is committed at its sampling edge, so a read of the same address at the next edge returns the new bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| addr | input | ADDR_W | Word address |
| sel_lo_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lane_sel_n | input | 2 | Byte-lane selects, active low; bit 0 lower byte, bit 1 upper byte |
| din | input | 2*LANE_W | Write data |
| dout | output | 2*LANE_W | Read data; a lane that is not valid reads as zero |
| dout_vld | output | 2 | Per-lane read-data valid |
| mode | output | 3 | Decoded mode of the previous edge: 0 deselect, 1 output disable, 2 read, 3 write lower, 4 write upper, 5 write word |

## Verification
On every cycle, assertions check the link from the control pins at one edge to the registered outputs at the next. They cover deselect by either enable and the case of no lane selected, the fact that write enable keeps the outputs quiet, output disable, valid lanes that stay within the selected lanes, and zero bytes on lanes that are not valid. They also check that a lane is never both read and written in the same cycle. Only the bench scenarios show data correctness. A shadow array exposes lane masking on writes, writes that were blocked by deselect or by having no lane selected, and read-after-write on the very next edge, because each of these appears only when an earlier write is read back.

// File: rtl/byte_lane_sram_pkg.sv
package byte_lane_sram_pkg;

  localparam int unsigned NUM_LANES = 2;

  typedef enum logic [2:0] {
    MODE_DESEL   = 3'd0,
    MODE_OFF     = 3'd1,
    MODE_READ    = 3'd2,
    MODE_WR_LO   = 3'd3,
    MODE_WR_HI   = 3'd4,
    MODE_WR_WORD = 3'd5
  } acc_mode_e;

endpackage

// File: rtl/byte_lane_sram_decode.sv
module byte_lane_sram_decode
  import byte_lane_sram_pkg::*;
(
  input  logic                 sel_lo_n,
  input  logic                 sel_hi,
  input  logic                 wr_n,
  input  logic                 oe_n,
  input  logic [NUM_LANES-1:0] lane_sel_n,
  output acc_mode_e            mode,
  output logic [NUM_LANES-1:0] lane_wr,
  output logic [NUM_LANES-1:0] lane_rd
);

  logic                 chip_on;
  logic [NUM_LANES-1:0] lanes_on;

  assign chip_on  = !sel_lo_n && sel_hi;
  assign lanes_on = ~lane_sel_n;

  always_comb begin
    mode    = MODE_DESEL;
    lane_wr = '0;
    lane_rd = '0;
    if (chip_on && (|lanes_on)) begin
      if (!wr_n) begin
        lane_wr = lanes_on;
        unique case (lanes_on)
          2'b01:   mode = MODE_WR_LO;
          2'b10:   mode = MODE_WR_HI;
          default: mode = MODE_WR_WORD;
        endcase
      end else if (!oe_n) begin
        mode    = MODE_READ;
        lane_rd = lanes_on;
      end else begin
        mode = MODE_OFF;
      end
    end
  end

endmodule

// File: rtl/byte_lane_sram_bank.sv
module byte_lane_sram_bank #(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) begin
      mem[addr] <= wdata;
    end
    if (rd) begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/byte_lane_sram_status.sv
module byte_lane_sram_status
  import byte_lane_sram_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  acc_mode_e            mode_d,
  input  logic [NUM_LANES-1:0] rd_d,
  output acc_mode_e            mode_q,
  output logic [NUM_LANES-1:0] vld_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_DESEL;
      vld_q  <= '0;
    end else begin
      mode_q <= mode_d;
      vld_q  <= rd_d;
    end
  end

endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
  import byte_lane_sram_pkg::*;
#(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned DATA_W = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 sel_lo_n,
  input  logic                 sel_hi,
  input  logic                 wr_n,
  input  logic                 oe_n,
  input  logic [NUM_LANES-1:0] lane_sel_n,
  input  logic [DATA_W-1:0]    din,
  output logic [DATA_W-1:0]    dout,
  output logic [NUM_LANES-1:0] dout_vld,
  output logic [2:0]           mode
);

  acc_mode_e            mode_d;
  acc_mode_e            mode_q;
  logic [NUM_LANES-1:0] lane_wr;
  logic [NUM_LANES-1:0] lane_rd;
  logic [NUM_LANES-1:0] vld_q;

  byte_lane_sram_decode u_decode (
    .sel_lo_n   (sel_lo_n),
    .sel_hi     (sel_hi),
    .wr_n       (wr_n),
    .oe_n       (oe_n),
    .lane_sel_n (lane_sel_n),
    .mode       (mode_d),
    .lane_wr    (lane_wr),
    .lane_rd    (lane_rd)
  );

  byte_lane_sram_status u_status (
    .clk    (clk),
    .rst    (rst),
    .mode_d (mode_d),
    .rd_d   (lane_rd),
    .mode_q (mode_q),
    .vld_q  (vld_q)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] rdata;

    byte_lane_sram_bank #(
      .DEPTH  (DEPTH),
      .LANE_W (LANE_W)
    ) u_bank (
      .clk   (clk),
      .wr    (lane_wr[g]),
      .rd    (lane_rd[g]),
      .addr  (addr),
      .wdata (din[g*LANE_W +: LANE_W]),
      .rdata (rdata)
    );

    assign dout[g*LANE_W +: LANE_W] = vld_q[g] ? rdata : '0;

    // R8: a lane without its valid flag carries zeros
    p_idle_lane_zero_r8: assert property (@(posedge clk) disable iff (rst)
      !dout_vld[g] |-> (dout[g*LANE_W +: LANE_W] == '0));
  end

  assign dout_vld = vld_q;
  assign mode     = mode_q;

  // R2: either enable inactive gives deselect with no valid lane
  p_deselect_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_lo_n || !sel_hi) |=> (mode == 3'd0) && (dout_vld == '0));

  // R2 / R3: no lane is written without selection of chip and lane
  p_no_stray_write_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_lo_n || !sel_hi || (&lane_sel_n)) |-> (lane_wr == '0));

  // R3: no lane selected behaves as deselect
  p_no_lane_desel_r3: assert property (@(posedge clk) disable iff (rst)
    (&lane_sel_n) |=> (mode == 3'd0) && (dout_vld == '0));

  // R4: reading and writing are exclusive in one cycle
  p_wr_rd_excl_r4: assert property (@(posedge clk) disable iff (rst)
    (|lane_wr) |-> (lane_rd == '0));

  // R5: a write cycle leaves every output lane off
  p_write_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> (dout_vld == '0));

  // R6: valid lanes stay within the lanes selected at the sampling edge
  p_vld_subset_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((dout_vld & $past(lane_sel_n)) == '0));

  // R7: output-disable mode
  p_out_disable_r7: assert property (@(posedge clk) disable iff (rst)
    (!sel_lo_n && sel_hi && !(&lane_sel_n) && wr_n && oe_n)
      |=> (mode == 3'd1) && (dout_vld == '0));

  // R1: reset returns the status to deselect
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mode == 3'd0) && (dout_vld == '0));

endmodule

// File: tb/test_byte_lane_sram.sv
`timescale 1ns/1ps
module test_byte_lane_sram;

  localparam int unsigned DEPTH  = 256;
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              sel_lo_n = 1'b1;
  logic              sel_hi = 1'b0;
  logic              wr_n = 1'b1;
  logic              oe_n = 1'b1;
  logic [1:0]        lane_sel_n = 2'b11;
  logic [15:0]       din = '0;
  logic [15:0]       dout;
  logic [1:0]        dout_vld;
  logic [2:0]        mode;

  logic [15:0] shadow [DEPTH];
  logic [1:0]  known  [DEPTH];

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  byte_lane_sram #(.DEPTH(DEPTH), .LANE_W(8)) i_byte_lane_sram (
    .clk(clk), .rst(rst), .addr(addr), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
    .wr_n(wr_n), .oe_n(oe_n), .lane_sel_n(lane_sel_n), .din(din),
    .dout(dout), .dout_vld(dout_vld), .mode(mode)
  );

  function automatic logic [2:0] exp_mode(logic cl, logic ch, logic w, logic o, logic [1:0] ls);
    if (cl || !ch || (&ls)) return 3'd0;
    if (!w) return (ls == 2'b10) ? 3'd3 : (ls == 2'b01) ? 3'd4 : 3'd5;
    if (!o) return 3'd2;
    return 3'd1;
  endfunction

  function automatic logic [1:0] exp_vld(logic [2:0] m, logic [1:0] ls);
    return (m == 3'd2) ? ~ls : 2'b00;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: drive after the falling edge, sample at the next falling edge
  task automatic access(logic cl, logic ch, logic w, logic o, logic [1:0] ls,
                        logic [ADDR_W-1:0] a, logic [15:0] d, string req);
    logic [2:0]  em;
    logic [1:0]  ev;
    logic [15:0] prev;
    logic [1:0]  pknown;
    sel_lo_n = cl; sel_hi = ch; wr_n = w; oe_n = o; lane_sel_n = ls;
    addr = a; din = d;
    em = exp_mode(cl, ch, w, o, ls);
    ev = exp_vld(em, ls);
    prev = shadow[a];
    pknown = known[a];
    @(posedge clk);
    @(negedge clk);
    chk(mode == em, {req, " mode"}, 32'(mode), 32'(em));
    chk(dout_vld == ev, {req, " vld"}, 32'(dout_vld), 32'(ev));
    for (int l = 0; l < 2; l++) begin
      if (!ev[l]) begin
        chk(dout[l*8 +: 8] == 8'h00, "R8 idle lane", 32'(dout[l*8 +: 8]), 32'h0);
      end else if (pknown[l]) begin
        chk(dout[l*8 +: 8] == prev[l*8 +: 8], {req, " data"},
            32'(dout[l*8 +: 8]), 32'(prev[l*8 +: 8]));
      end
    end
    if (em >= 3'd3) begin
      for (int l = 0; l < 2; l++) begin
        if (!ls[l]) begin
          shadow[a][l*8 +: 8] = d[l*8 +: 8];
          known[a][l] = 1'b1;
        end
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = '0;
      known[i]  = 2'b00;
    end
    seed_init = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mode == 3'd0, "R1 mode", 32'(mode), 32'd0);
    chk(dout_vld == 2'b00, "R1 vld", 32'(dout_vld), 32'd0);
    chk(dout == 16'h0, "R1 dout", 32'(dout), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(mode == 3'd0 && dout_vld == 2'b00, "R1 after reset", 32'(mode), 32'd0);

    // R4: word write, then R9: read on the next edge
    access(0, 1, 0, 1, 2'b00, 8'd5, 16'hA55A, "R4 word write");
    access(0, 1, 1, 0, 2'b00, 8'd5, 16'h0000, "R9 read after write");
    // R4: lower lane only, then upper lane only
    access(0, 1, 0, 1, 2'b10, 8'd5, 16'h1234, "R4 lower write");
    access(0, 1, 0, 1, 2'b01, 8'd5, 16'hBEEF, "R4 upper write");
    access(0, 1, 1, 0, 2'b00, 8'd5, 16'h0000, "R4 masked readback");
    // R6: per-lane reads
    access(0, 1, 1, 0, 2'b10, 8'd5, 16'h0000, "R6 lower read");
    access(0, 1, 1, 0, 2'b01, 8'd5, 16'h0000, "R6 upper read");
    // R2: writes blocked by either enable
    access(1, 1, 0, 0, 2'b00, 8'd5, 16'hFFFF, "R2 active-low off");
    access(0, 0, 0, 0, 2'b00, 8'd5, 16'hFFFF, "R2 active-high off");
    access(0, 1, 1, 0, 2'b00, 8'd5, 16'h0000, "R2 contents kept");
    // R3: no lane selected
    access(0, 1, 0, 0, 2'b11, 8'd5, 16'h0F0F, "R3 no lane write");
    access(0, 1, 1, 0, 2'b11, 8'd5, 16'h0000, "R3 no lane read");
    access(0, 1, 1, 0, 2'b00, 8'd5, 16'h0000, "R3 contents kept");
    // R5: write with output enable active
    access(0, 1, 0, 0, 2'b00, 8'd9, 16'hC3C3, "R5 write quiet");
    // R7: output disable
    access(0, 1, 1, 1, 2'b00, 8'd9, 16'h0000, "R7 output disable");
    access(0, 1, 1, 0, 2'b00, 8'd9, 16'h0000, "R9 readback");

    // random mix on a small address pool
    for (int n = 0; n < 4000; n++) begin
      logic cl, ch;
      cl = ($urandom % 8) == 0;
      ch = ($urandom % 8) != 0;
      access(cl, ch, 1'($urandom), 1'($urandom), 2'($urandom),
             ADDR_W'($urandom % 16), 16'($urandom), "R6 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule